// File: doc/BRIEF.md
# DMA Channel Address and Word-Count Register File

This block holds the address and transfer-count state for a set of DMA channels. Every channel keeps two 16-bit pairs, a base and a current copy of its address and of its word count. A host loads them through an 8-bit port. A shared byte pointer steers each access to the low or the high half. The base copy is write-only. It is the value the current copy returns to when a channel is set to reinitialize itself.

During service, a transfer sequencer presents the index of the active channel and that channel's mode bits. It gives one step pulse per transfer. On each step the block:
- moves the current address up or down by one, or holds it for the source channel of a fixed-source memory-to-memory fill;
- decrements the current count;
- flags terminal count;
- flags when the low address byte carries or borrows, so the sequencer knows the upper address byte must be reissued.

When terminal count or an external end-of-process is seen on a channel with autoinitialize selected, the current registers are restored from the base registers.

Top module: `dma_addr_count_regs`

## Requirements
- R1: After reset every register of every channel is zero, the byte pointer selects the low byte, and `tc_o` and `carry_o` are low.
- R2: A host write (`host_we_i`) stores `host_wdata_i` into both the base and the current copy of the selected register. `host_sel_cnt_i`=1 selects the word count and 0 selects the address, in the channel given by `host_ch_i`. The pointer value 0 selects bits 7:0 and 1 selects bits 15:8.
- R3: The byte pointer inverts after every host byte read or write. It is forced to 0 by `ptr_clr_i` or `mclr_i`, and a clear wins over a toggle in the same cycle.
- R4: `host_rdata_o` shows the byte of the selected channel's current address or current count chosen by the pointer. The base values are never returned.
- R5: Each step on the active channel lowers its current count by one, wrapping from 0000h to FFFFh.
- R6: Each step raises the active channel's current address by one when `addr_dec_i`=0 and lowers it by one when `addr_dec_i`=1.
- R7: `tc_o` is high during a step whose active channel count is 0000h. A count programmed as N therefore gives terminal count on step N+1.
- R8: With `autoinit_i`=1, terminal count or `eop_i` on the active channel restores that channel's current address and count from its base copies, in place of the step update.
- R9: With `autoinit_i`=0, a channel that reaches terminal count is left with count FFFFh, and `eop_i` alters no register.
- R10: While `mem2mem_i`=1 and `fix_src_i`=1, steps on channel 0 leave its address unchanged but still decrement its count. Other channels are not affected by these two inputs.
- R11: `carry_o` is high during a step that moves the address when the low address byte is FFh while incrementing, or 00h while decrementing.
- R12: A host write to the active channel in the same cycle as a step takes precedence. That step is dropped: there is no count or address change, no `tc_o` and no reload.
- R13: `cur_addr_o` always shows the current address of the channel given by `act_ch_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host byte write strobe |
| host_re_i | input | 1 | Host byte read strobe |
| host_ch_i | input | 2 | Channel addressed by the host |
| host_sel_cnt_i | input | 1 | 1 = word count, 0 = address |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| ptr_clr_i | input | 1 | Clear byte pointer command |
| mclr_i | input | 1 | Master clear command |
| step_i | input | 1 | One pulse per completed transfer |
| act_ch_i | input | 2 | Channel under service |
| addr_dec_i | input | 1 | Address direction of active channel, 1 = down |
| fix_src_i | input | 1 | Hold channel 0 address in memory-to-memory mode |
| mem2mem_i | input | 1 | Memory-to-memory operation active |
| autoinit_i | input | 1 | Autoinitialize enabled for active channel |
| eop_i | input | 1 | External end of process |
| cur_addr_o | output | 16 | Current address of active channel |
| tc_o | output | 1 | Terminal count on this step |
| carry_o | output | 1 | Low address byte carry/borrow on this step |

## Verification
A wrong pointer state shows at once, because the next host byte lands in or comes from the wrong half. It is visible in the very next two-byte readback. A broken count or reload shows as `tc_o` arriving one step early or late, or as a readback that differs from the base value after the expected terminal step. An address fault shows on `cur_addr_o` one cycle after the step. A missed carry shows in the same cycle as the step that crosses a 256-byte boundary.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_BYTE_W = 8;

  // Low byte about to wrap in the stepping direction.
  function automatic logic low_wraps(input logic [DEF_BYTE_W-1:0] lo, input logic dec);
    return dec ? (lo == '0) : (lo == '1);
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic toggle_i,
  output logic ptr_o
);
  logic ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= 1'b0;
    else if (clr_i)    ptr_q <= 1'b0;
    else if (toggle_i) ptr_q <= ~ptr_q;
  end

  assign ptr_o = ptr_q;

  // R3
  ptr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ptr_o);

  // R3
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_i && !clr_i) |=> (ptr_o != $past(ptr_o)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned REG_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              sel_cnt_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic              dec_i,
  input  logic              hold_i,
  input  logic              reload_i,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic [REG_W-1:0]  cur_cnt_o
);
  logic [REG_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic             wr;

  assign wr = wr_lo_i | wr_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else if (wr) begin
      if (sel_cnt_i) begin
        if (wr_hi_i) begin
          base_cnt_q[REG_W-1:BYTE_W] <= wdata_i;
          cur_cnt_q[REG_W-1:BYTE_W]  <= wdata_i;
        end else begin
          base_cnt_q[BYTE_W-1:0] <= wdata_i;
          cur_cnt_q[BYTE_W-1:0]  <= wdata_i;
        end
      end else begin
        if (wr_hi_i) begin
          base_addr_q[REG_W-1:BYTE_W] <= wdata_i;
          cur_addr_q[REG_W-1:BYTE_W]  <= wdata_i;
        end else begin
          base_addr_q[BYTE_W-1:0] <= wdata_i;
          cur_addr_q[BYTE_W-1:0]  <= wdata_i;
        end
      end
    end else if (reload_i) begin
      cur_addr_q <= base_addr_q;
      cur_cnt_q  <= base_cnt_q;
    end else if (step_i) begin
      cur_cnt_q <= cur_cnt_q - 1'b1;
      if (!hold_i) cur_addr_q <= dec_i ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr && !reload_i) |=> (cur_cnt_q == $past(cur_cnt_q) - 1'b1));

  // R8
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !wr) |=> (cur_addr_q == base_addr_q && cur_cnt_q == base_cnt_q));

  // R10
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && hold_i && !wr && !reload_i) |=> $stable(cur_addr_q));
endmodule

// File: rtl/dma_addr_count_regs.sv
module dma_addr_count_regs #(
  parameter int unsigned NUM_CH = dma_regs_pkg::DEF_NUM_CH,
  parameter int unsigned BYTE_W = dma_regs_pkg::DEF_BYTE_W,
  localparam int unsigned REG_W = 2 * BYTE_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [CH_W-1:0]   host_ch_i,
  input  logic              host_sel_cnt_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic              ptr_clr_i,
  input  logic              mclr_i,
  input  logic              step_i,
  input  logic [CH_W-1:0]   act_ch_i,
  input  logic              addr_dec_i,
  input  logic              fix_src_i,
  input  logic              mem2mem_i,
  input  logic              autoinit_i,
  input  logic              eop_i,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic              tc_o,
  output logic              carry_o
);
  logic             ptr;
  logic             step_eff, hold_act, end_evt;
  logic [REG_W-1:0] addr_q [NUM_CH];
  logic [REG_W-1:0] cnt_q  [NUM_CH];
  logic [REG_W-1:0] host_word;

  dma_byte_ptr i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ptr_clr_i | mclr_i),
    .toggle_i(host_we_i | host_re_i),
    .ptr_o   (ptr)
  );

  // Host write on the serviced channel suppresses that cycle's step.
  assign step_eff = step_i && !(host_we_i && host_ch_i == act_ch_i);
  assign hold_act = (act_ch_i == '0) && mem2mem_i && fix_src_i;
  assign tc_o     = step_eff && (cnt_q[act_ch_i] == '0);
  assign end_evt  = tc_o || (eop_i && !(host_we_i && host_ch_i == act_ch_i));
  assign carry_o  = step_eff && !hold_act &&
                    dma_regs_pkg::low_wraps(addr_q[act_ch_i][BYTE_W-1:0], addr_dec_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_h, act_c, hold_c;
    assign sel_h = host_we_i && (host_ch_i == CH_W'(c));
    assign act_c = (act_ch_i == CH_W'(c));
    if (c == 0) begin : g_hold
      assign hold_c = mem2mem_i && fix_src_i;
    end else begin : g_nohold
      assign hold_c = 1'b0;
    end

    dma_chan_regs #(.BYTE_W(BYTE_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (sel_h && !ptr),
      .wr_hi_i   (sel_h && ptr),
      .sel_cnt_i (host_sel_cnt_i),
      .wdata_i   (host_wdata_i),
      .step_i    (step_eff && act_c),
      .dec_i     (addr_dec_i),
      .hold_i    (hold_c),
      .reload_i  (act_c && autoinit_i && end_evt),
      .cur_addr_o(addr_q[c]),
      .cur_cnt_o (cnt_q[c])
    );
  end

  assign host_word    = host_sel_cnt_i ? cnt_q[host_ch_i] : addr_q[host_ch_i];
  assign host_rdata_o = ptr ? host_word[REG_W-1:BYTE_W] : host_word[BYTE_W-1:0];
  assign cur_addr_o   = addr_q[act_ch_i];

  // R7
  tc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !autoinit_i) |=> (cnt_q[$past(act_ch_i)] == '1));

  // R11
  carry_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && !autoinit_i) |=>
      (addr_q[$past(act_ch_i)][REG_W-1:BYTE_W] != $past(cur_addr_o[REG_W-1:BYTE_W])));

  // R12
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && host_we_i && host_ch_i == act_ch_i) |-> !tc_o && !carry_o);
endmodule

// File: tb/test_dma_addr_count_regs.sv
module test_dma_addr_count_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_we = 0, host_re = 0, host_sel_cnt = 0, ptr_clr = 0, mclr = 0;
  logic [1:0]  host_ch = 0, act_ch = 0;
  logic [7:0]  host_wdata = 0, rdata;
  logic        step = 0, dec = 0, fix_src = 0, mem2mem = 0, autoinit = 0, eop = 0;
  logic [15:0] cur_addr;
  logic        tc, carry;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dma_addr_count_regs i_dma_addr_count_regs (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_re_i(host_re),
    .host_ch_i(host_ch), .host_sel_cnt_i(host_sel_cnt), .host_wdata_i(host_wdata),
    .host_rdata_o(rdata), .ptr_clr_i(ptr_clr), .mclr_i(mclr), .step_i(step),
    .act_ch_i(act_ch), .addr_dec_i(dec), .fix_src_i(fix_src), .mem2mem_i(mem2mem),
    .autoinit_i(autoinit), .eop_i(eop), .cur_addr_o(cur_addr), .tc_o(tc), .carry_o(carry)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  ch;
    logic        sel;
    logic [15:0] val;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0, 2'd0, 1'b0, 16'h1234}, '{1'b0, 2'd0, 1'b1, 16'h00A5},
    '{1'b0, 2'd1, 1'b0, 16'h2345}, '{1'b0, 2'd1, 1'b1, 16'hBEEF},
    '{1'b0, 2'd2, 1'b0, 16'hFF00}, '{1'b0, 2'd2, 1'b1, 16'h0102},
    '{1'b0, 2'd3, 1'b0, 16'h8001}, '{1'b0, 2'd3, 1'b1, 16'h7FFE},
    '{1'b1, 2'd3, 1'b1, 16'h7FFE}, '{1'b1, 2'd0, 1'b0, 16'h1234},
    '{1'b1, 2'd2, 1'b1, 16'h0102}, '{1'b1, 2'd1, 1'b0, 16'h2345},
    '{1'b1, 2'd0, 1'b1, 16'h00A5}, '{1'b1, 2'd3, 1'b0, 16'h8001},
    '{1'b1, 2'd1, 1'b1, 16'hBEEF}, '{1'b1, 2'd2, 1'b0, 16'hFF00}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] ch, input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_ch = ch; host_sel_cnt = sel; host_wdata = d;
    @(posedge clk); #1 host_we = 0;
  endtask

  task automatic rd_byte(input logic [1:0] ch, input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_re = 1; host_ch = ch; host_sel_cnt = sel;
    #1 d = rdata;
    @(posedge clk); #1 host_re = 0;
  endtask

  task automatic wr16(input logic [1:0] ch, input logic sel, input logic [15:0] v);
    wr_byte(ch, sel, v[7:0]);
    wr_byte(ch, sel, v[15:8]);
  endtask

  task automatic rd16(input logic [1:0] ch, input logic sel, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_byte(ch, sel, lo);
    rd_byte(ch, sel, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_clr(input logic master);
    @(negedge clk);
    if (master) mclr = 1; else ptr_clr = 1;
    @(posedge clk); #1 mclr = 0; ptr_clr = 0;
  endtask

  task automatic step_chk(input logic [1:0] ch, input logic exp_tc, input logic exp_cy,
                          input string tag);
    @(negedge clk);
    act_ch = ch; step = 1;
    #1 check({tag, " tc"}, {15'd0, tc}, {15'd0, exp_tc});
    check({tag, " carry"}, {15'd0, carry}, {15'd0, exp_cy});
    @(posedge clk); #1 step = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    check("R1 tc", {15'd0, tc}, 16'd0);
    check("R1 carry", {15'd0, carry}, 16'd0);
    check("R1 cur_addr", cur_addr, 16'h0000);
    rd16(2'd0, 1'b0, v); check("R1 ch0 addr", v, 16'h0000);
    rd16(2'd3, 1'b1, v); check("R1 ch3 cnt", v, 16'h0000);

    // R2 R4 table walk
    foreach (VECS[i]) begin
      if (VECS[i].rd) begin
        rd16(VECS[i].ch, VECS[i].sel, v);
        check($sformatf("R2 R4 vec%0d", i), v, VECS[i].val);
      end else begin
        wr16(VECS[i].ch, VECS[i].sel, VECS[i].val);
      end
    end

    // R3 pointer clear by command, master clear, toggle on read
    wr_byte(2'd1, 1'b0, 8'hAA); pulse_clr(1'b0);
    wr_byte(2'd1, 1'b0, 8'h55); pulse_clr(1'b0);
    rd16(2'd1, 1'b0, v); check("R3 clear cmd", v, 16'h2355);
    wr_byte(2'd1, 1'b0, 8'h11); pulse_clr(1'b1);
    wr_byte(2'd1, 1'b0, 8'h66); pulse_clr(1'b1);
    rd16(2'd1, 1'b0, v); check("R3 master clear", v, 16'h2366);
    rd_byte(2'd1, 1'b0, b); wr_byte(2'd1, 1'b0, 8'h77); pulse_clr(1'b0);
    rd16(2'd1, 1'b0, v); check("R3 read toggles", v, 16'h7766);

    // R5 R6 R7 R9 R11 increment, count 2 -> three transfers
    wr16(2'd2, 1'b0, 16'h10FE); wr16(2'd2, 1'b1, 16'h0002);
    dec = 0; autoinit = 0;
    step_chk(2'd2, 1'b0, 1'b0, "R7 step1");
    check("R6 inc", cur_addr, 16'h10FF);
    step_chk(2'd2, 1'b0, 1'b1, "R11 step2");
    check("R11 carry addr", cur_addr, 16'h1100);
    step_chk(2'd2, 1'b1, 1'b0, "R7 step3");
    check("R6 inc3", cur_addr, 16'h1101);
    rd16(2'd2, 1'b1, v); check("R9 cnt wraps", v, 16'hFFFF);

    // R6 R11 decrement with borrow, R7 count 0
    wr16(2'd3, 1'b0, 16'h2000); wr16(2'd3, 1'b1, 16'h0000);
    dec = 1;
    step_chk(2'd3, 1'b1, 1'b1, "R11 borrow");
    check("R6 dec", cur_addr, 16'h1FFF);
    rd16(2'd3, 1'b1, v); check("R5 cnt dec", v, 16'hFFFF);
    dec = 0;

    // R8 autoinit on terminal count and on external eop
    wr16(2'd1, 1'b0, 16'h4000); wr16(2'd1, 1'b1, 16'h0001);
    autoinit = 1;
    step_chk(2'd1, 1'b0, 1'b0, "R8 s1");
    check("R8 mid addr", cur_addr, 16'h4001);
    step_chk(2'd1, 1'b1, 1'b0, "R8 s2");
    check("R8 tc reload addr", cur_addr, 16'h4000);
    rd16(2'd1, 1'b1, v); check("R8 tc reload cnt", v, 16'h0001);
    step_chk(2'd1, 1'b0, 1'b0, "R8 s3");
    @(negedge clk); eop = 1; @(posedge clk); #1 eop = 0;
    check("R8 eop reload addr", cur_addr, 16'h4000);
    rd16(2'd1, 1'b1, v); check("R8 eop reload cnt", v, 16'h0001);

    // R9 eop without autoinit changes nothing
    autoinit = 0;
    step_chk(2'd1, 1'b0, 1'b0, "R9 s");
    @(negedge clk); eop = 1; @(posedge clk); #1 eop = 0;
    check("R9 eop addr", cur_addr, 16'h4001);
    rd16(2'd1, 1'b1, v); check("R9 eop cnt", v, 16'h0000);

    // R10 fixed source on channel 0 only
    wr16(2'd0, 1'b0, 16'h0500); wr16(2'd0, 1'b1, 16'h0005);
    mem2mem = 1; fix_src = 1;
    step_chk(2'd0, 1'b0, 1'b0, "R10 s1");
    step_chk(2'd0, 1'b0, 1'b0, "R10 s2");
    check("R10 addr held", cur_addr, 16'h0500);
    rd16(2'd0, 1'b1, v); check("R10 cnt dec", v, 16'h0003);
    step_chk(2'd1, 1'b1, 1'b0, "R10 ch1");
    check("R10 ch1 moves", cur_addr, 16'h4002);
    mem2mem = 0; fix_src = 0;

    // R12 host write beats a step on the active channel
    wr16(2'd2, 1'b0, 16'h3000); wr16(2'd2, 1'b1, 16'h0000);
    @(negedge clk);
    act_ch = 2'd2; step = 1; host_we = 1; host_ch = 2'd2; host_sel_cnt = 0; host_wdata = 8'h34;
    #1 check("R12 no tc", {15'd0, tc}, 16'd0);
    @(posedge clk); #1 step = 0; host_we = 0;
    wr_byte(2'd2, 1'b0, 8'h30);
    rd16(2'd2, 1'b0, v); check("R12 addr", v, 16'h3034);
    rd16(2'd2, 1'b1, v); check("R12 cnt kept", v, 16'h0000);

    // R13 output follows active channel
    @(negedge clk); act_ch = 2'd0; #1 check("R13 ch0", cur_addr, 16'h0500);
    @(negedge clk); act_ch = 2'd3; #1 check("R13 ch3", cur_addr, 16'h1FFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule